// File: doc/BRIEF.md
# GPIO Bank with Pin-Change Interrupts

This block is a 32-pin general-purpose I/O bank that software reaches through a small 32-bit register window. Each pin has a direction bit and an output latch. Separate write-one-to-set and write-one-to-clear addresses change these, so software never has to read, modify and write them back. The pad buffers sit outside the block. It drives an output vector and an output-enable vector and receives an input vector.

The lowest eight pins can raise interrupts. One control word holds four bytes of per-pin enables: rising, falling, debounce and level mode. In edge mode the rise and fall bits select which transitions are caught. In level mode the same two bits select active-high or active-low. Detected events latch into a status register that software clears by writing ones. The OR of the status bits drives a single registered interrupt line.

Every input passes through a synchronizer. A pin with debounce enabled accepts a new value only after the value has held for a fixed run of clocks.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous reset, every pin is an input (pad_oe all zero), the output latch is zero, the interrupt-control word and the status are zero, irq_out is low, and a read of offset 0x00 returns all ones.
- R2: Writing offset 0x04 makes each pin written as one an output, and writing offset 0x08 makes each pin written as one an input. A direction bit reads one for an input. Bits written as zero are unchanged. pad_oe is the inverse of the direction register, and a read of offset 0x00 returns the direction register.
- R3: Writing offset 0x10 sets, and writing offset 0x14 clears, the output-latch bits written as one. pad_out shows the latch. A read of offset 0x10 returns the latch, not the pad level.
- R4: A read of offset 0x0C returns pad_in after a two-flop synchronizer.
- R5: Writing offset 0x18 sets, and writing offset 0x1C clears, bits of the interrupt-control word. Its fields are rise enables [7:0], fall enables [15:8], debounce enables [23:16] and level-mode selects [31:24]. A read of offset 0x18 returns the word.
- R6: With the level-mode bit clear, a rise bit latches status on a low-to-high change of that pin, and a fall bit latches status on a high-to-low change. With both bits set, either change latches status.
- R7: With the level-mode bit set, the rise bit latches status on every cycle the pin is high, and the fall bit latches status on every cycle the pin is low. A status bit cannot be cleared while its condition holds.
- R8: With debounce enabled, a pin change is accepted only after the synchronized input has differed from the accepted value for 4 consecutive clocks. A 3-clock pulse is ignored and a 4-clock pulse is accepted.
- R9: Writing ones to offset 0x20 clears those status bits. A read of offset 0x24 returns the status, with bits 31:8 always zero. Pins 8 to 31 never cause an interrupt.
- R10: irq_out is the OR of all status bits, registered one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe; data appears on bus_rdata after the next edge |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, held between reads |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables, one per driven pin |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: 32 pins, 8 interrupt-capable pins, a two-stage synchronizer and a 4-clock debounce. These values put the edge of the debounce window (a 3-clock pulse against a 4-clock pulse) within reach of short directed stimulus. They also let the bench toggle pins above the interrupt byte to show that those pins cannot raise interrupts. A behavioural model follows every clock and predicts the read data, the pad vectors and the interrupt line, including level-mode status that is re-asserted while software tries to clear it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FIELD_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_DIR     = 6'h00,
    OFS_DIR_OUT = 6'h04,
    OFS_DIR_IN  = 6'h08,
    OFS_PIN     = 6'h0C,
    OFS_OUT_SET = 6'h10,
    OFS_OUT_CLR = 6'h14,
    OFS_ICT_SET = 6'h18,
    OFS_ICT_CLR = 6'h1C,
    OFS_ST_CLR  = 6'h20,
    OFS_ST      = 6'h24
  } reg_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic q
);
  localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (!en) begin
      q   <= din;
      cnt <= '0;
    end else if (din == q) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      q   <= din;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] rise_en,
  input  logic [N-1:0] fall_en,
  input  logic [N-1:0] level_mode,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status
);
  logic [N-1:0] prev;
  logic [N-1:0] edge_hit, level_hit, hit;

  always_comb begin
    edge_hit  = (rise_en & lvl & ~prev) | (fall_en & ~lvl & prev);
    level_hit = (rise_en & lvl) | (fall_en & ~lvl);
    hit       = (level_mode & level_hit) | (~level_mode & edge_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= '0;
      status <= '0;
    end else begin
      prev   <= lvl;
      status <= (status & ~clr) | hit;
    end
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned IRQ_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DB_CYCLES   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wen,
  input  logic                bus_ren,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic                irq_out
);
  localparam int unsigned ICT_W = 4 * FIELD_W;
  localparam int unsigned RISE_LO = 0;
  localparam int unsigned FALL_LO = FIELD_W;
  localparam int unsigned DBNC_LO = 2 * FIELD_W;
  localparam int unsigned LVL_LO  = 3 * FIELD_W;

  logic [NUM_PINS-1:0] dir_q, out_q, pin_s;
  logic [NUM_PINS-1:0] wpins;
  logic [ICT_W-1:0]    ict_q;
  logic [IRQ_PINS-1:0] stat_q, filt, clr_hit;
  logic [IRQ_PINS-1:0] rise_en, fall_en, dbnc_en, lvl_mode;
  logic [DATA_W-1:0]   rd_mux;

  assign wpins = bus_wdata[NUM_PINS-1:0];

  function automatic logic wr_at(input logic [ADDR_W-1:0] a);
    return bus_wen && (bus_addr == a);
  endfunction

  // Register file: direction, output latch, interrupt control
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      out_q <= '0;
      ict_q <= '0;
    end else begin
      if (wr_at(OFS_DIR_OUT)) dir_q <= dir_q & ~wpins;
      if (wr_at(OFS_DIR_IN))  dir_q <= dir_q | wpins;
      if (wr_at(OFS_OUT_SET)) out_q <= out_q | wpins;
      if (wr_at(OFS_OUT_CLR)) out_q <= out_q & ~wpins;
      if (wr_at(OFS_ICT_SET)) ict_q <= ict_q | bus_wdata[ICT_W-1:0];
      if (wr_at(OFS_ICT_CLR)) ict_q <= ict_q & ~bus_wdata[ICT_W-1:0];
    end
  end

  assign rise_en  = ict_q[RISE_LO +: IRQ_PINS];
  assign fall_en  = ict_q[FALL_LO +: IRQ_PINS];
  assign dbnc_en  = ict_q[DBNC_LO +: IRQ_PINS];
  assign lvl_mode = ict_q[LVL_LO  +: IRQ_PINS];
  assign clr_hit  = wr_at(OFS_ST_CLR) ? bus_wdata[IRQ_PINS-1:0] : '0;

  assign pad_out = out_q;
  assign pad_oe  = ~dir_q;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pad_in),
    .dout (pin_s)
  );

  for (genvar i = 0; i < IRQ_PINS; i++) begin : g_dbnc
    gpio_debounce #(.HOLD(DB_CYCLES)) u_dbnc (
      .clk (clk),
      .rst (rst),
      .en  (dbnc_en[i]),
      .din (pin_s[i]),
      .q   (filt[i])
    );
  end

  gpio_irq_detect #(.N(IRQ_PINS)) u_detect (
    .clk        (clk),
    .rst        (rst),
    .lvl        (filt),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .level_mode (lvl_mode),
    .clr        (clr_hit),
    .status     (stat_q)
  );

  // Read mux, registered
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_DIR:                  rd_mux[NUM_PINS-1:0] = dir_q;
      OFS_PIN:                  rd_mux[NUM_PINS-1:0] = pin_s;
      OFS_OUT_SET, OFS_OUT_CLR: rd_mux[NUM_PINS-1:0] = out_q;
      OFS_ICT_SET:              rd_mux[ICT_W-1:0]    = ict_q;
      OFS_ST:                   rd_mux[IRQ_PINS-1:0] = stat_q;
      default:                  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (bus_ren) bus_rdata <= rd_mux;
      irq_out <= |stat_q;
    end
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned IRQ_PINS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wen,
  input logic                bus_ren,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic                irq_out,
  input logic [IRQ_PINS-1:0] stat_q
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && !irq_out)); // R1

  AST_DIR_OUT_TAKES: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && bus_addr == OFS_DIR_OUT) |=>
      ((pad_oe & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0]))); // R2

  AST_OUT_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && bus_addr == OFS_OUT_SET) |=>
      ((pad_out & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0]))); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_wen |=> $stable(pad_out)); // R3

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_ren && bus_addr == OFS_ST) |=> (bus_rdata[DATA_W-1:IRQ_PINS] == '0)); // R9

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|stat_q) |=> irq_out); // R10

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (stat_q == '0) |=> !irq_out); // R10
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS), .IRQ_PINS(IRQ_PINS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wen   (bus_wen),
  .bus_ren   (bus_ren),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq_out   (irq_out),
  .stat_q    (stat_q)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0;
  logic        bus_ren = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_out;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank u_dut (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_s1, m_s2, m_dir, m_out, m_ctl, m_rdata;
  logic [7:0]  m_filt, m_prev, m_stat;
  int          m_cnt [8];
  logic        m_irq;
  string       m_rtag = "R1";

  always @(posedge clk) begin
    logic [7:0] hit;
    logic [7:0] clr;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_dir = 32'hFFFF_FFFF; m_out = 0; m_ctl = 0;
      m_rdata = 0; m_filt = 0; m_prev = 0; m_stat = 0; m_irq = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
    end else begin
      if (bus_ren) begin
        case (bus_addr)
          6'h00: begin m_rdata = m_dir; m_rtag = "R2"; end
          6'h0C: begin m_rdata = m_s2; m_rtag = "R4"; end
          6'h10, 6'h14: begin m_rdata = m_out; m_rtag = "R3"; end
          6'h18: begin m_rdata = m_ctl; m_rtag = "R5"; end
          6'h24: begin m_rdata = {24'h0, m_stat}; m_rtag = "R9"; end
          default: begin m_rdata = 0; m_rtag = "R9"; end
        endcase
      end
      m_irq = (m_stat != 0);
      hit = 0;
      for (int i = 0; i < 8; i++) begin
        if (m_ctl[24+i])
          hit[i] = (m_ctl[i] && m_filt[i]) || (m_ctl[8+i] && !m_filt[i]);
        else
          hit[i] = (m_ctl[i] && m_filt[i] && !m_prev[i]) ||
                   (m_ctl[8+i] && !m_filt[i] && m_prev[i]);
      end
      clr = (bus_wen && bus_addr == 6'h20) ? bus_wdata[7:0] : 8'h0;
      m_stat = (m_stat & ~clr) | hit;
      m_prev = m_filt;
      for (int i = 0; i < 8; i++) begin
        if (!m_ctl[16+i]) begin m_filt[i] = m_s2[i]; m_cnt[i] = 0; end
        else if (m_s2[i] == m_filt[i]) m_cnt[i] = 0;
        else if (m_cnt[i] == 3) begin m_filt[i] = m_s2[i]; m_cnt[i] = 0; end
        else m_cnt[i] = m_cnt[i] + 1;
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
      if (bus_wen) begin
        case (bus_addr)
          6'h04: m_dir = m_dir & ~bus_wdata;
          6'h08: m_dir = m_dir | bus_wdata;
          6'h10: m_out = m_out | bus_wdata;
          6'h14: m_out = m_out & ~bus_wdata;
          6'h18: m_ctl = m_ctl | bus_wdata;
          6'h1C: m_ctl = m_ctl & ~bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 pad_oe vs model", pad_oe, ~m_dir);
      chk("R3 pad_out vs model", pad_out, m_out);
      chk("R10 irq_out vs model", {31'h0, irq_out}, {31'h0, m_irq});
      chk({m_rtag, " rdata vs model"}, bus_rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_ren = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_ren = 1'b0;
    v = bus_rdata;
  endtask

  task automatic pads(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wipe();
    wr(6'h1C, 32'hFFFF_FFFF);
    idle(6);
    wr(6'h20, 32'hFFFF_FFFF);
    idle(2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_errs++;
    n_checks++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pad_oe after reset", pad_oe, 32'h0);
    chk("R1 pad_out after reset", pad_out, 32'h0);
    chk("R1 irq_out after reset", {31'h0, irq_out}, 32'h0);
    rd(6'h00, v); chk("R1 direction all inputs", v, 32'hFFFF_FFFF);
    rd(6'h18, v); chk("R1 control word clear", v, 32'h0);
    rd(6'h24, v); chk("R1 status clear", v, 32'h0);

    // R2 direction
    wr(6'h04, 32'h0000_00F0); chk("R2 make outputs", pad_oe, 32'h0000_00F0);
    wr(6'h04, 32'h0000_0001); chk("R2 zero bits unchanged", pad_oe, 32'h0000_00F1);
    rd(6'h00, v); chk("R2 direction readback", v, ~32'h0000_00F1);
    wr(6'h08, 32'h0000_0010); chk("R2 make input", pad_oe, 32'h0000_00E1);

    // R3 output latch
    wr(6'h10, 32'h8000_00A5); chk("R3 set bits", pad_out, 32'h8000_00A5);
    wr(6'h14, 32'h0000_0005); chk("R3 clear bits", pad_out, 32'h8000_00A0);
    rd(6'h10, v); chk("R3 latch not pad level", v, 32'h8000_00A0);

    // R4 pin value through synchronizer
    pads(32'h1234_5678);
    idle(3);
    rd(6'h0C, v); chk("R4 pin value", v, 32'h1234_5678);
    pads(32'h0);
    idle(4);

    // R5 control word set/clear
    wr(6'h18, 32'h0102_0304);
    rd(6'h18, v); chk("R5 control set", v, 32'h0102_0304);
    wr(6'h1C, 32'h0100_0004);
    rd(6'h18, v); chk("R5 control clear", v, 32'h0002_0300);
    wipe();

    // R6 edge modes
    wr(6'h18, 32'h0000_0001);          // rise pin0
    pads(32'h0000_0001); idle(6);
    rd(6'h24, v); chk("R6 rising edge pin0", v, 32'h0000_0001);
    chk("R10 irq raised", {31'h0, irq_out}, 32'h1);
    wr(6'h20, 32'h0000_0001); idle(2);
    rd(6'h24, v); chk("R9 status cleared", v, 32'h0);
    chk("R10 irq dropped", {31'h0, irq_out}, 32'h0);
    pads(32'h0); idle(6);
    rd(6'h24, v); chk("R6 falling ignored when only rise set", v, 32'h0);
    wr(6'h18, 32'h0000_0200);          // fall pin1
    pads(32'h0000_0002); idle(6);
    rd(6'h24, v); chk("R6 rise ignored on fall-only pin1", v & 32'h2, 32'h0);
    pads(32'h0); idle(6);
    rd(6'h24, v); chk("R6 falling edge pin1", v & 32'h2, 32'h2);
    wipe();
    wr(6'h18, 32'h0000_0404);          // both edges pin2
    pads(32'h0000_0004); idle(6);
    rd(6'h24, v); chk("R6 both: rise pin2", v, 32'h4);
    wr(6'h20, 32'h4); idle(2);
    pads(32'h0); idle(6);
    rd(6'h24, v); chk("R6 both: fall pin2", v, 32'h4);
    wipe();

    // R7 level modes
    wr(6'h18, 32'h0800_0008);          // level high pin3
    pads(32'h0000_0008); idle(6);
    rd(6'h24, v); chk("R7 level high pin3", v, 32'h8);
    wr(6'h20, 32'h8); idle(1);
    rd(6'h24, v); chk("R7 clear refused while high", v, 32'h8);
    pads(32'h0); idle(6);
    wr(6'h20, 32'h8); idle(1);
    rd(6'h24, v); chk("R7 clear once low", v, 32'h0);
    wr(6'h18, 32'h1000_1000);          // level low pin4 (pin is low)
    idle(3);
    rd(6'h24, v); chk("R7 level low pin4", v & 32'h10, 32'h10);
    pads(32'h0000_0010); idle(6);
    wr(6'h20, 32'h10); idle(1);
    rd(6'h24, v); chk("R7 clear once high", v & 32'h10, 32'h0);
    wipe();

    // R9 upper pins never interrupt
    wr(6'h18, 32'hFFFF_FFFF);
    wr(6'h1C, 32'h00FF_0000);
    pads(32'hFFFF_FF00); idle(6);
    pads(32'h0000_0000); idle(6);
    wr(6'h1C, 32'hFFFF_FFFF); idle(4);
    wr(6'h20, 32'hFFFF_FFFF); idle(2);
    pads(32'hFFFF_FF00); idle(6);
    rd(6'h24, v); chk("R9 upper pins no status", v, 32'h0);
    pads(32'h0); idle(4);
    wipe();

    // R8 debounce on pin5
    wr(6'h18, 32'h0020_0020);
    idle(4);
    pads(32'h0000_0020); idle(2);
    pads(32'h0); idle(8);
    rd(6'h24, v); chk("R8 3-clock pulse ignored", v, 32'h0);
    pads(32'h0000_0020); idle(3);
    pads(32'h0); idle(8);
    rd(6'h24, v); chk("R8 4-clock pulse accepted", v, 32'h20);
    wipe();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule